// File: doc/BRIEF.md
# GPIO Controller with Pin Interrupts

This block gives software control over 64 general-purpose pins through a small register bus. Each pin is either driven by the block or left as an input, and it can be handed to an alternate-function peripheral instead of the GPIO data registers. Pins are grouped in two banks of 32. A bank register at an even address covers pins 0 to 31. The register at the next odd address covers pins 32 to 63, with bit position equal to the pin number minus 32.

Pins 0 to 15 can also raise interrupts. Every pad input passes through a two-flop synchroniser. On those sixteen pins, three configuration bits (edge, high, low) choose the detection mode. Edge modes capture into sticky pending latches, which software clears by writing a 1 and then a 0 to a clear register. Level modes report the synchronised pin level directly. A per-pin enable gates each condition into one combined interrupt line.

The register bus is a single write strobe with an address and write data. Writes land on the clock edge where the strobe is high. Read data is a combinational function of the address.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, all direction, select, output, mode (edge, high, low), enable and clear registers read 0. `irq` is low and `pad_oe` is all zero.
- R2: Address map. Direction is at 0/1, select at 2/3, output data at 4/5 and input data at 6/7 (read only). The even address holds pins 0-31 at bit p. The odd address holds pins 32-63 at bit p-32. Writing one bank leaves the other bank unchanged.
- R3: With select 0, `pad_oe[p]` equals direction bit p (1 = output) and `pad_out[p]` equals output bit p. With select 1, `pad_oe[p]` and `pad_out[p]` follow `alt_oe[p]` and `alt_out[p]`.
- R4: The input data registers return the pad level after two synchroniser flops. A level applied to `pad_in` is readable by the third rising clock edge.
- R5: Interrupt mode registers: edge at 8, high at 10, low at 9. Pin p uses bit p. With edge = 0, the condition is (high AND level) OR (low AND NOT level). It follows the synchronised pin level and is not latched. (0,0,1) is level-low, (0,1,0) is level-high, and (0,0,0) is no interrupt.
- R6: With edge = 1, a synchronised rising transition sets the pin's sticky pending bit when high = 1. A falling transition sets it when low = 1. So (1,1,0) is rising, (1,0,1) is falling, (1,1,1) is both edges, and (1,0,0) never fires.
- R7: Clear register at address 12. While a pin's clear bit is 1, its pending bit is held at 0 and edges are not recorded. Writing the bit back to 0 re-arms detection. Clear has no effect on level modes.
- R8: Enable register at address 11. `irq` is the OR over pins 0-15 of (condition AND enable). Detection runs while a pin is disabled, so a pending edge raises `irq` once the pin is enabled. The status register at 13 reads the conditions before the enable gate.
- R9: Only pins 0-15 are interrupt-capable. Bits 16-31 of registers 8-13 read 0 whatever is written.
- R10: A register write takes effect on the rising edge where `bus_wr` is high. Reads are combinational from `bus_addr`.
- R11: Clearing a pin's edge bit discards its pending bit. Setting edge again does not bring back an old event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pad_in | input | 64 | Pad input levels |
| pad_out | output | 64 | Pad output values |
| pad_oe | output | 64 | Pad output enables |
| alt_out | input | 64 | Alternate-function output values |
| alt_oe | input | 64 | Alternate-function output enables |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench sweeps every pin across both banks, one pin at a time. A design with a shifted bank boundary, or one that writes both banks at once, drives the wrong `pad_oe` bit. It also sweeps all eight (edge, high, low) combinations on each of the sixteen interrupt pins, through a low, rise, clear, fall, clear sequence. A latched level mode would keep `irq` high after a clear, and swapped high/low roles would fire on the wrong edge. Further runs target:
- A rising edge that arrives while clear is held. It must be lost, not replayed.
- An edge recorded while the pin is disabled. It must appear the moment the pin is enabled.
- Leaving edge mode and returning. This must not revive an old pending bit.
- The sixteen-bit width of the interrupt registers.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_DIR0  = 4'd0,
    A_DIR1  = 4'd1,
    A_SEL0  = 4'd2,
    A_SEL1  = 4'd3,
    A_OUT0  = 4'd4,
    A_OUT1  = 4'd5,
    A_IN0   = 4'd6,
    A_IN1   = 4'd7,
    A_TEDGE = 4'd8,
    A_TLO   = 4'd9,
    A_THI   = 4'd10,
    A_IEN   = 4'd11,
    A_ICLR  = 4'd12,
    A_ISTAT = 4'd13
  } reg_addr_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= din;
      sync_q <= meta_q;
    end
  end

  assign dout = sync_q;
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int NPINS  = 64,
  parameter int BANK_W = BUS_W,
  parameter int IRQ_N  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  output logic [BUS_W-1:0]  rdata,
  input  logic [NPINS-1:0]  sync_in,
  input  logic [IRQ_N-1:0]  irq_stat,
  output logic [NPINS-1:0]  dir_q,
  output logic [NPINS-1:0]  sel_q,
  output logic [NPINS-1:0]  out_q,
  output logic [IRQ_N-1:0]  tedge_q,
  output logic [IRQ_N-1:0]  thi_q,
  output logic [IRQ_N-1:0]  tlo_q,
  output logic [IRQ_N-1:0]  en_q,
  output logic [IRQ_N-1:0]  clr_q
);
  localparam int NBANK = NPINS / BANK_W;
  localparam int BSEL_W = (NBANK > 1) ? $clog2(NBANK) : 1;

  logic [NPINS-1:0] dir_d, sel_d, out_d;
  logic [IRQ_N-1:0] tedge_d, thi_d, tlo_d, en_d, clr_d;
  logic [BSEL_W-1:0] bank;
  reg_addr_e         a;

  assign a    = reg_addr_e'(addr);
  assign bank = BSEL_W'(addr[0]);

  always_comb begin
    dir_d   = dir_q;
    sel_d   = sel_q;
    out_d   = out_q;
    tedge_d = tedge_q;
    thi_d   = thi_q;
    tlo_d   = tlo_q;
    en_d    = en_q;
    clr_d   = clr_q;
    unique case (a)
      A_DIR0, A_DIR1: dir_d[bank*BANK_W +: BANK_W] = wdata;
      A_SEL0, A_SEL1: sel_d[bank*BANK_W +: BANK_W] = wdata;
      A_OUT0, A_OUT1: out_d[bank*BANK_W +: BANK_W] = wdata;
      A_TEDGE:        tedge_d = wdata[IRQ_N-1:0];
      A_THI:          thi_d   = wdata[IRQ_N-1:0];
      A_TLO:          tlo_d   = wdata[IRQ_N-1:0];
      A_IEN:          en_d    = wdata[IRQ_N-1:0];
      A_ICLR:         clr_d   = wdata[IRQ_N-1:0];
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      sel_q   <= '0;
      out_q   <= '0;
      tedge_q <= '0;
      thi_q   <= '0;
      tlo_q   <= '0;
      en_q    <= '0;
      clr_q   <= '0;
    end else if (wr) begin
      dir_q   <= dir_d;
      sel_q   <= sel_d;
      out_q   <= out_d;
      tedge_q <= tedge_d;
      thi_q   <= thi_d;
      tlo_q   <= tlo_d;
      en_q    <= en_d;
      clr_q   <= clr_d;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (a)
      A_DIR0, A_DIR1: rdata = dir_q[bank*BANK_W +: BANK_W];
      A_SEL0, A_SEL1: rdata = sel_q[bank*BANK_W +: BANK_W];
      A_OUT0, A_OUT1: rdata = out_q[bank*BANK_W +: BANK_W];
      A_IN0, A_IN1:   rdata = sync_in[bank*BANK_W +: BANK_W];
      A_TEDGE:        rdata[IRQ_N-1:0] = tedge_q;
      A_THI:          rdata[IRQ_N-1:0] = thi_q;
      A_TLO:          rdata[IRQ_N-1:0] = tlo_q;
      A_IEN:          rdata[IRQ_N-1:0] = en_q;
      A_ICLR:         rdata[IRQ_N-1:0] = clr_q;
      A_ISTAT:        rdata[IRQ_N-1:0] = irq_stat;
      default: ;
    endcase
  end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int IRQ_N = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IRQ_N-1:0] lvl,
  input  logic [IRQ_N-1:0] tedge,
  input  logic [IRQ_N-1:0] thi,
  input  logic [IRQ_N-1:0] tlo,
  input  logic [IRQ_N-1:0] en,
  input  logic [IRQ_N-1:0] clr,
  output logic [IRQ_N-1:0] lvl_prev,
  output logic [IRQ_N-1:0] pend,
  output logic [IRQ_N-1:0] cond,
  output logic             irq
);
  logic [IRQ_N-1:0] prev_q, pend_q, pend_d;

  for (genvar g = 0; g < IRQ_N; g++) begin : g_pin
    logic rise, fall, hit, lvl_act;
    assign rise    = lvl[g] & ~prev_q[g];
    assign fall    = ~lvl[g] & prev_q[g];
    assign hit     = (thi[g] & rise) | (tlo[g] & fall);
    assign lvl_act = (thi[g] & lvl[g]) | (tlo[g] & ~lvl[g]);
    // clear and edge-off both dominate a new hit
    assign pend_d[g] = (clr[g] | ~tedge[g]) ? 1'b0 : (pend_q[g] | hit);
    assign cond[g]   = tedge[g] ? pend_q[g] : lvl_act;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= lvl;
      pend_q <= pend_d;
    end
  end

  assign irq      = |(cond & en);
  assign lvl_prev = prev_q;
  assign pend     = pend_q;
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
  parameter int NPINS = 64
) (
  input  logic [NPINS-1:0] sel,
  input  logic [NPINS-1:0] dir,
  input  logic [NPINS-1:0] dout,
  input  logic [NPINS-1:0] alt_out,
  input  logic [NPINS-1:0] alt_oe,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe
);
  for (genvar p = 0; p < NPINS; p++) begin : g_pad
    assign pad_oe[p]  = sel[p] ? alt_oe[p]  : dir[p];
    assign pad_out[p] = sel[p] ? alt_out[p] : dout[p];
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_pkg::*;
#(
  parameter int NPINS = 64,
  parameter int IRQ_N = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  input  logic [NPINS-1:0]  alt_out,
  input  logic [NPINS-1:0]  alt_oe,
  output logic              irq
);
  logic [1:0]       rst_pipe;
  logic             rst_n_i;
  logic [NPINS-1:0] sync_q, dir_q, sel_q, out_q;
  logic [IRQ_N-1:0] tedge_q, thi_q, tlo_q, en_q, clr_q;
  logic [IRQ_N-1:0] lvl_prev, pend_q, cond;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_i = rst_pipe[1];

  gpio_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n_i), .din(pad_in), .dout(sync_q)
  );

  gpio_regs #(.NPINS(NPINS), .BANK_W(BUS_W), .IRQ_N(IRQ_N)) u_regs (
    .clk(clk), .rst_n(rst_n_i), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .sync_in(sync_q),
    .irq_stat(cond), .dir_q(dir_q), .sel_q(sel_q), .out_q(out_q),
    .tedge_q(tedge_q), .thi_q(thi_q), .tlo_q(tlo_q), .en_q(en_q),
    .clr_q(clr_q)
  );

  gpio_irq_detect #(.IRQ_N(IRQ_N)) u_det (
    .clk(clk), .rst_n(rst_n_i), .lvl(sync_q[IRQ_N-1:0]),
    .tedge(tedge_q), .thi(thi_q), .tlo(tlo_q), .en(en_q), .clr(clr_q),
    .lvl_prev(lvl_prev), .pend(pend_q), .cond(cond), .irq(irq)
  );

  gpio_pad_mux #(.NPINS(NPINS)) u_mux (
    .sel(sel_q), .dir(dir_q), .dout(out_q), .alt_out(alt_out),
    .alt_oe(alt_oe), .pad_out(pad_out), .pad_oe(pad_oe)
  );
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk #(
  parameter int IRQ_N = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic [3:0]       bus_addr,
  input logic [31:0]      bus_wdata,
  input logic [IRQ_N-1:0] en_q,
  input logic [IRQ_N-1:0] clr_q,
  input logic [IRQ_N-1:0] tedge_q,
  input logic [IRQ_N-1:0] thi_q,
  input logic [IRQ_N-1:0] tlo_q,
  input logic [IRQ_N-1:0] lvl,
  input logic [IRQ_N-1:0] lvl_prev,
  input logic [IRQ_N-1:0] pend_q,
  input logic             irq
);
  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq);

  // R7
  clr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_q != '0) |=> ((pend_q & $past(clr_q)) == '0));

  // R6
  pend_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~$past(pend_q)) != '0) |-> ($past(lvl ^ lvl_prev) != '0));

  // R10
  wr_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 4'd11) |=> (en_q == $past(bus_wdata[IRQ_N-1:0])));

  // R5
  lvl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((~tedge_q & tlo_q & ~thi_q & ~lvl & en_q) != '0) |-> irq);
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.IRQ_N(IRQ_N)) u_chk (
  .clk(clk), .rst_n(rst_n_i), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .en_q(en_q), .clr_q(clr_q), .tedge_q(tedge_q),
  .thi_q(thi_q), .tlo_q(tlo_q), .lvl(sync_q[IRQ_N-1:0]),
  .lvl_prev(lvl_prev), .pend_q(pend_q), .irq(irq)
);

// File: tb/sim_gpio_irq_ctrl.sv
module sim_gpio_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [63:0] pad_in, pad_out, pad_oe, alt_out, alt_oe;
  logic        irq;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .alt_out(alt_out),
    .alt_oe(alt_oe), .irq(irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic pulse_clr(input logic [31:0] m);
    wr(4'd12, m);
    wr(4'd12, 32'h0);
    #1;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=done", WATCHDOG);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    pad_in = '0; alt_out = '0; alt_oe = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    waitc(4);

    // R1: reset state
    for (int a = 0; a < 13; a++) begin
      if (a == 6 || a == 7) continue;
      rd(4'(a), r);
      chk($sformatf("R1 reg%0d", a), 64'(r), 64'h0);
    end
    chk("R1 irq", 64'(irq), 64'h0);
    chk("R1 pad_oe", pad_oe, 64'h0);

    // R2 R3: one pin at a time across both banks
    for (int p = 0; p < 64; p++) begin
      logic [31:0] m;
      m = 32'h1 << (p % 32);
      wr(4'd0, (p < 32) ? m : 32'h0);
      wr(4'd1, (p < 32) ? 32'h0 : m);
      wr(4'd4, (p < 32) ? m : 32'h0);
      wr(4'd5, (p < 32) ? 32'h0 : m);
      chk($sformatf("R2 R3 oe pin%0d", p), pad_oe, 64'h1 << p);
      chk($sformatf("R2 R3 out pin%0d", p), pad_out, 64'h1 << p);
    end

    // R3: alternate function handover
    begin
      logic [63:0] s, d, o, exp_oe, exp_out;
      s = 64'h0000_00FF_0000_F00F; d = 64'h3333_0000_FFFF_0000;
      o = 64'hCCCC_5555_AAAA_0F0F;
      alt_oe = 64'hFFFF_0F0F_00FF_FFFF; alt_out = 64'h1234_5678_9ABC_DEF0;
      wr(4'd0, d[31:0]); wr(4'd1, d[63:32]);
      wr(4'd4, o[31:0]); wr(4'd5, o[63:32]);
      wr(4'd2, s[31:0]); wr(4'd3, s[63:32]);
      exp_oe  = (s & alt_oe)  | (~s & d);
      exp_out = (s & alt_out) | (~s & o);
      chk("R3 alt oe", pad_oe, exp_oe);
      chk("R3 alt out", pad_out, exp_out);
      wr(4'd2, 32'h0); wr(4'd3, 32'h0);
      chk("R3 sel off oe", pad_oe, d);
    end

    // R4: input synchroniser latency and bank readback
    pad_in = 64'hA5C3_0F96_1234_8001;
    @(negedge clk); bus_addr = 4'd6; #1;
    chk("R4 not yet visible", 64'(bus_rdata), 64'h0);
    waitc(3);
    rd(4'd6, r); chk("R4 in lo", 64'(r), 64'h1234_8001);
    rd(4'd7, r); chk("R4 in hi", 64'(r), 64'hA5C3_0F96);
    pad_in = '0;
    waitc(4);

    // R9: only sixteen interrupt bits exist
    for (int a = 8; a < 13; a++) begin
      wr(4'(a), 32'hFFFF_FFFF);
      rd(4'(a), r);
      chk($sformatf("R9 width reg%0d", a), 64'(r), 64'h0000_FFFF);
      wr(4'(a), 32'h0);
    end

    // R5 R6 R7 R8: every mode on every interrupt pin
    for (int p = 0; p < 16; p++) begin
      for (int md = 0; md < 8; md++) begin
        logic e, h, l;
        logic [31:0] m;
        e = md[2]; h = md[1]; l = md[0];
        m = 32'h1 << p;
        pad_in = '0; waitc(4);
        wr(4'd8,  e ? m : 32'h0);
        wr(4'd10, h ? m : 32'h0);
        wr(4'd9,  l ? m : 32'h0);
        wr(4'd11, m);
        pulse_clr(m);
        chk($sformatf("R5 R6 low p%0d m%0d", p, md), 64'(irq), 64'(e ? 1'b0 : l));
        pad_in[p] = 1'b1; waitc(4);
        chk($sformatf("R5 R6 rise p%0d m%0d", p, md), 64'(irq), 64'(h));
        pulse_clr(m);
        chk($sformatf("R7 clr hi p%0d m%0d", p, md), 64'(irq), 64'(e ? 1'b0 : h));
        pad_in[p] = 1'b0; waitc(4);
        chk($sformatf("R5 R6 fall p%0d m%0d", p, md), 64'(irq), 64'(l));
        pulse_clr(m);
        chk($sformatf("R7 clr lo p%0d m%0d", p, md), 64'(irq), 64'(e ? 1'b0 : l));
      end
    end

    // R7: edge arriving while clear is held is lost
    pad_in = '0; waitc(4);
    wr(4'd8, 32'h8); wr(4'd10, 32'h8); wr(4'd9, 32'h0); wr(4'd11, 32'h8);
    wr(4'd12, 32'h8);
    pad_in[3] = 1'b1; waitc(4);
    chk("R7 held clear blocks edge", 64'(irq), 64'h0);
    wr(4'd12, 32'h0); waitc(1);
    chk("R7 released clear no replay", 64'(irq), 64'h0);
    pad_in[3] = 1'b0; waitc(4);
    pad_in[3] = 1'b1; waitc(4);
    chk("R7 re-armed", 64'(irq), 64'h1);

    // R8: disabled pin still detects, status shows it
    pulse_clr(32'h8);
    wr(4'd11, 32'h0);
    pad_in[3] = 1'b0; waitc(4);
    pad_in[3] = 1'b1; waitc(4);
    chk("R8 disabled no irq", 64'(irq), 64'h0);
    rd(4'd13, r);
    chk("R8 status pending", 64'(r), 64'h8);
    wr(4'd11, 32'h8); #1;
    chk("R8 enable shows pending", 64'(irq), 64'h1);

    // R11: leaving edge mode drops pending
    wr(4'd8, 32'h0); wr(4'd10, 32'h0);
    chk("R11 edge off", 64'(irq), 64'h0);
    wr(4'd10, 32'h8); wr(4'd8, 32'h8); #1;
    chk("R11 no stale event", 64'(irq), 64'h0);

    // R10: write visible right after its edge
    wr(4'd0, 32'hDEAD_BEEF);
    rd(4'd0, r);
    chk("R10 write latency", 64'(r), 64'hDEAD_BEEF);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule